// File: doc/BRIEF.md
# Prescaled Refresh Interval Timer

This block paces memory refresh. An 8-bit up-counter advances on count enables derived from the bus clock through a prescaler with seven ratios, or is held when the prescaler is switched off. When a count enable arrives while the counter equals an 8-bit compare constant, the counter returns to 0, a sticky match flag is raised and a one-cycle match pulse is emitted. The interval is therefore (constant+1) prescaled ticks. A refresh sequencer outside the block can use the pulse. The flag, gated by an enable bit, forms an interrupt request.

Software reaches the block through a plain synchronous register port with a 2-bit address. A write is taken on the clock edge where `reg_wr` is high. Read data is combinational from the address. The port has no data stream, so there is no valid/ready handshake: every access completes in one cycle and nothing can stall.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset, every address reads 0, and `irq` and `match_pulse` are low. The timer is stopped and the interrupt is disabled.
- R2: Address 0 is the control/status word. Bit 7 is the match flag, bit 6 is the interrupt enable and bits 5:3 are the clock select. Bits 15:8 and 2:0 always read 0.
- R3: With clock select 000 the counter holds its value and no match occurs.
- R4: Clock select codes 1 to 7 advance the counter once every 4, 16, 64, 256, 1024, 2048 and 4096 bus cycles respectively.
- R5: A match occurs when a count enable arrives while the counter equals the constant. On that clock edge the counter becomes 0 and the flag becomes 1. Successive match pulses are (constant+1)×ratio cycles apart.
- R6: Writing address 0 with bit 7 = 0 clears the flag. Writing it with bit 7 = 1 leaves the flag unchanged. Bits 6:3 of the same write are stored.
- R7: If a match and a flag-clearing write fall on the same edge, the flag ends up 1.
- R8: `irq` is high exactly while both the flag and the interrupt enable are 1.
- R9: `match_pulse` is high for one cycle after each match, whatever the interrupt enable is.
- R10: Address 1 is the counter and address 2 is the constant (low 8 bits, upper bits read 0). Address 3 reads 0. A counter write overrides a count enable on the same edge, and that edge produces no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_sel` (combinational) |
| match_pulse | output | 1 | One-cycle pulse per compare match |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag-clearing write that lands on the same edge as a match, together with a counter write that lands exactly on a count enable. The prescaler phase cannot be seen at the ports. The bench therefore runs at the fastest ratio with a constant of 0, so matches recur every 4 cycles. It takes the match pulse as the phase reference and counts edges from it to place the write on the next match edge. A control write placed one edge earlier shows that the flag really does clear when there is no collision.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int REG_DW  = 16;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 3;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int CKS_LSB  = 3;

  typedef enum logic [1:0] {
    ADDR_CSR  = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_NONE = 2'd3
  } rit_addr_e;

  // log2 of the divide ratio selected by a clock-select code (code 0 unused)
  function automatic int div_shift(input int code);
    if (code <= 4) return 2 * code;
    else           return code + 5;
  endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
  parameter int SEL_W = rit_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 2 ** SEL_W;
  localparam int DIV_W = rit_pkg::div_shift(NSEL - 1);

  logic [DIV_W-1:0] div_q;
  logic [NSEL-1:0]  hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign hit[0] = 1'b0;
  for (genvar g = 1; g < NSEL; g++) begin : g_tap
    localparam int SH = rit_pkg::div_shift(g);
    assign hit[g] = &div_q[SH-1:0];
  end

  assign tick = hit[sel];
endmodule

// File: rtl/rit_csr.sv
module rit_csr #(
  parameter int SEL_W = rit_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_flag,
  input  logic             wr_ie,
  input  logic [SEL_W-1:0] wr_cks,
  input  logic             set_evt,
  output logic             flag,
  output logic             ie,
  output logic [SEL_W-1:0] cks
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
      cks  <= '0;
    end else begin
      if (set_evt)                flag <= 1'b1;
      else if (wr_en && !wr_flag) flag <= 1'b0;
      if (wr_en) begin
        ie  <= wr_ie;
        cks <= wr_cks;
      end
    end
  end
endmodule

// File: rtl/rit_count.sv
module rit_count #(
  parameter int CNT_W = rit_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             match_evt,
  output logic             match_pulse
);
  assign match_evt = tick && !cnt_wr && (cnt_q == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cmp_q       <= '0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= match_evt;
      if (cnt_wr)         cnt_q <= wdata;
      else if (match_evt) cnt_q <= '0;
      else if (tick)      cnt_q <= cnt_q + 1'b1;
      if (cmp_wr) cmp_q <= wdata;
    end
  end
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int REG_DW = rit_pkg::REG_DW,
  parameter int CNT_W  = rit_pkg::CNT_W,
  parameter int SEL_W  = rit_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              match_pulse,
  output logic              irq
);
  import rit_pkg::*;

  localparam int CKS_MSB = CKS_LSB + SEL_W - 1;

  logic             csr_wr, cnt_wr, cmp_wr;
  logic             tick, set_evt;
  logic             flag_q, ie_q;
  logic [SEL_W-1:0] cks_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             unused_wbits;

  assign csr_wr = reg_wr && (reg_sel == ADDR_CSR);
  assign cnt_wr = reg_wr && (reg_sel == ADDR_CNT);
  assign cmp_wr = reg_wr && (reg_sel == ADDR_CMP);
  assign unused_wbits = ^{reg_wdata[REG_DW-1:IE_BIT+2], reg_wdata[CKS_LSB-1:0],
                          reg_wdata[REG_DW-1:CNT_W]};

  rit_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(cks_q), .tick(tick)
  );

  rit_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
    .wdata(reg_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .match_evt(set_evt), .match_pulse(match_pulse)
  );

  rit_csr #(.SEL_W(SEL_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr),
    .wr_flag(reg_wdata[FLAG_BIT]), .wr_ie(reg_wdata[IE_BIT]),
    .wr_cks(reg_wdata[CKS_MSB:CKS_LSB]), .set_evt(set_evt),
    .flag(flag_q), .ie(ie_q), .cks(cks_q)
  );

  assign irq = flag_q && ie_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      ADDR_CSR: begin
        reg_rdata[FLAG_BIT]        = flag_q;
        reg_rdata[IE_BIT]          = ie_q;
        reg_rdata[CKS_MSB:CKS_LSB] = cks_q;
      end
      ADDR_CNT:  reg_rdata[CNT_W-1:0] = cnt_q;
      ADDR_CMP:  reg_rdata[CNT_W-1:0] = cmp_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
  parameter int REG_DW = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              match_pulse,
  input logic              irq,
  input logic              flag_q,
  input logic              ie_q,
  input logic [SEL_W-1:0]  cks_q,
  input logic [CNT_W-1:0]  cnt_q
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[REG_DW-1:8] == '0 && reg_rdata[2:0] == '0));

  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cks_q == '0 && !(reg_wr && reg_sel == 2'd1)) |=> (cnt_q == $past(cnt_q) && !match_pulse));

  assert_pulse_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (flag_q && cnt_q == '0) || $past(reg_wr && reg_sel == 2'd1));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  assert_wr1_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[7] && !flag_q) |=> (!flag_q || match_pulse));

  assert_wr0_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && !reg_wdata[7]) |=> (flag_q == match_pulse));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q |-> !irq) and ((match_pulse && ie_q) |-> irq));

  assert_cnt_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (cnt_q == $past(reg_wdata[CNT_W-1:0]) && !match_pulse));
endmodule

bind refresh_interval_timer rit_checker #(.REG_DW(REG_DW), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .match_pulse(match_pulse), .irq(irq), .flag_q(flag_q),
  .ie_q(ie_q), .cks_q(cks_q), .cnt_q(cnt_q)
);

// File: tb/refresh_interval_timer_test.sv
module refresh_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        match_pulse, irq;

  int n_vec = 0, n_bad = 0, n_pulse = 0;
  logic        probe = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  refresh_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_pulse(match_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data when a read is probed
  always @(negedge clk) begin
    if (match_pulse) n_pulse++;
    if (probe && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(reg_rdata), int'(e));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    reg_sel = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  // returns at the negedge where a match pulse is high; n = cycles since the prior pulse
  task automatic meas(output int n);
    do @(negedge clk); while (!match_pulse);
    n = 0;
    do begin @(negedge clk); n++; end while (!match_pulse);
  endtask

  function automatic int ratio_shift(input int code);
    return (code <= 4) ? 2 * code : code + 5;
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    summary();
  end

  initial begin
    int n, p0;
    int codes[8] = '{1, 1, 2, 3, 4, 5, 6, 7};
    int cons[8]  = '{0, 3, 2, 1, 0, 0, 0, 1};
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    rd(2'd0, 16'h0000, "R1 csr");
    rd(2'd1, 16'h0000, "R1 cnt");
    rd(2'd2, 16'h0000, "R1 cmp");
    rd(2'd3, 16'h0000, "R1 addr3");
    chk("R1 irq", int'(irq), 0);
    chk("R1 pulse", int'(match_pulse), 0);

    // R2/R6: reserved bits read 0, writing 1 to flag keeps it 0
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h0078, "R2 R6 csr layout");
    wr(2'd0, 16'h0000);

    // R3: stopped count
    wr(2'd2, 16'h0040);
    wr(2'd1, 16'h0033);
    p0 = n_pulse;
    repeat (300) @(posedge clk); #1;
    rd(2'd1, 16'h0033, "R3 held count");
    chk("R3 no pulse", n_pulse - p0, 0);

    // R10: constant and counter readback, upper bits 0
    wr(2'd2, 16'hFFA5);
    rd(2'd2, 16'h00A5, "R10 cmp readback");

    // R4/R5: interval for every ratio
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'(cons[i]));
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'(codes[i] << 3));
      if (i == 1) reg_sel = 2'd1;
      meas(n);
      chk($sformatf("R4 R5 period code %0d const %0d", codes[i], cons[i]),
          n, (cons[i] + 1) << ratio_shift(codes[i]));
      if (i == 1) chk("R5 counter zero at match", int'(reg_rdata), 0);
    end

    // R6: stop keeping flag, then clear
    wr(2'd0, 16'h0080);
    rd(2'd0, 16'h0080, "R6 write 1 keeps flag");
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0000, "R6 write 0 clears flag");

    // R8/R9: interrupt gating
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h00C8);
    meas(n);
    chk("R9 pulse with ie on", n, 4);
    wr(2'd0, 16'h00C0);
    chk("R8 irq flag and ie", int'(irq), 1);
    wr(2'd0, 16'h0040);
    chk("R8 irq flag cleared", int'(irq), 0);
    wr(2'd0, 16'h0008);
    meas(n);
    chk("R9 pulse with ie off", n, 4);
    chk("R8 irq ie off", int'(irq), 0);

    // R7: control clear one edge before a match, then clear on the match edge
    meas(n);
    repeat (2) @(posedge clk); #1;
    wr(2'd0, 16'h0008);
    rd(2'd0, 16'h0008, "R7 control clear");
    repeat (4) @(posedge clk); #1;
    wr(2'd0, 16'h0008);
    rd(2'd0, 16'h0088, "R7 set beats clear");

    // R10: counter write on a count-enable edge wins and suppresses the match
    meas(n);
    repeat (3) @(posedge clk); #1;
    wr(2'd1, 16'h0005);
    rd(2'd1, 16'h0005, "R10 write wins");
    chk("R10 no match on write edge", int'(match_pulse), 0);

    summary();
  end
endmodule